// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the frequency of a bus clock in a system clock tree, from the values currently held in the tree's control registers. The tree starts at a fixed 24 MHz reference. It multiplies the reference up to a system PLL frequency. It derives two fractional-divider taps from the PLL. A four-way pre-peripheral selector picks one of these sources. Three integer dividers in series then produce the AHB, IPG and peripheral (PER) clocks.

A caller presents the raw 32-bit register words and a query code, then pulses `start`. The block copies the fields it needs and walks the chain one division at a time on a shared iterative restoring divider with 64-bit intermediates. It then raises `done` for one cycle with the 32-bit answer on `freq`. Queries for fixed clocks return one cycle after `start`. No clocks are generated and no clock switching takes place.

Top module: `clkcalc_top`

## Requirements
- R1: After reset, `done` is low and `freq` reads 0.
- R2: The PLL frequency is 24,000,000 × 22 when bit 0 of `pll_word` is 1, and 24,000,000 × 20 when it is 0.
- R3: Tap A uses the fraction in bits [5:0] of `pfd_word`, and tap B uses the fraction in bits [21:16]. Each tap equals floor(PLL × 18 / fraction).
- R4: Bits [19:18] of `mux_word` select the peripheral source. 0 selects the PLL, 1 selects tap B, 2 selects tap A, and 3 selects floor(tap B / 2).
- R5: AHB = floor(peripheral / (1 + `bus_word`[12:10])), and IPG = floor(AHB / (1 + `bus_word`[9:8])).
- R6: Query code 1 returns IPG. Query code 2 returns PER = floor(IPG / (1 + `per_word`[5:0])).
- R7: Query code 3 returns 32768, code 4 returns 24,000,000 and code 5 returns 3,000,000, each with `done` on the first cycle after `start`. Code 0 and codes 6 to 15 return 0.
- R8: When the selected tap's fraction field is zero, that tap counts as 0 and every clock derived from it is 0, with no divide fault.
- R9: Every accepted `start` produces exactly one `done` pulse, one cycle wide, and `freq` carries the result in that cycle.
- R10: A `start` pulse that arrives while a computation is running is ignored. The words and the query are sampled only on the accepted `start`.
- R11: Intermediate values are carried to 64 bits and only the final result is cut to its low 32 bits, so large values wrap modulo 2^32.
- R12: With the reset words (pll 0x00013001, pfd 0x1018101B, mux 0x00022324, bus 0x00018D40, per 0x00F00000), the chain gives PLL 528 MHz, tap A 352 MHz, tap B 396 MHz and AHB 132 MHz. Queries 1 and 2 then both return 66,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to compute |
| query | input | 4 | Code of the clock to report |
| pll_word | input | 32 | System PLL control word |
| pfd_word | input | 32 | Shared fractional-divider word |
| mux_word | input | 32 | Bus clock multiplexer word |
| bus_word | input | 32 | Bus clock divider word |
| per_word | input | 32 | Peripheral clock divider word |
| done | output | 1 | One-cycle result strobe |
| freq | output | 32 | Resulting frequency in Hz |

## Verification
The reset words confirm the documented 66 MHz operating point. Directed words then hold the bus dividers at 1 and step the selector through its four values, which shows that the two fraction fields are read from their own bit positions and that only the last selector value halves its source. Further directed cases cover a zero fraction, a fraction of 1 that overflows 32 bits, fixed-clock queries with their one-cycle latency, and a second `start` sent during a running computation with different words. Random words and queries across all 16 codes exercise every divider field together, and each result is compared with a model computed in the bench.

// File: rtl/clkcalc_pkg.sv
package clkcalc_pkg;

  localparam longint unsigned REF_HZ  = 64'd24_000_000;
  localparam longint unsigned SLOW_HZ = 64'd32_768;
  localparam int unsigned     REF_POST_DIV = 8;
  localparam int unsigned     PLL_MUL_HI = 22;
  localparam int unsigned     PLL_MUL_LO = 20;
  localparam int unsigned     TAP_MUL    = 18;

  localparam int unsigned PLL_SEL_BIT = 0;
  localparam int unsigned TAPA_LSB    = 0;
  localparam int unsigned TAPB_LSB    = 16;
  localparam int unsigned SRC_LSB     = 18;
  localparam int unsigned SRC_W       = 2;
  localparam int unsigned AHB_LSB     = 10;
  localparam int unsigned AHB_W       = 3;
  localparam int unsigned IPG_LSB     = 8;
  localparam int unsigned IPG_W       = 2;
  localparam int unsigned PER_LSB     = 0;

  typedef enum logic [3:0] {
    Q_NONE    = 4'd0,
    Q_IPG     = 4'd1,
    Q_PER     = 4'd2,
    Q_SLOW    = 4'd3,
    Q_REF     = 4'd4,
    Q_REF_DIV = 4'd5
  } query_e;

endpackage

// File: rtl/clkcalc_div.sv
module clkcalc_div #(
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_W);

  logic [NUM_W-1:0] quo_q, quo_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [DEN_W-1:0] den_q, den_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             busy, step_en;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  assign busy    = (cnt_q != '0);
  assign step_en = start_i | busy;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    ge    = (trial >= {1'b0, den_q});
    quo_n  = quo_q;
    rem_n  = rem_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (start_i) begin
      quo_n = num_i;
      rem_n = '0;
      den_n = den_i;
      cnt_n = CNT_MAX;
    end else if (busy) begin
      quo_n  = {quo_q[NUM_W-2:0], ge};
      rem_n  = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_n  = cnt_q - 1'b1;
      done_n = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else if (step_en) begin
      quo_q <= quo_n;
      rem_q <= rem_n;
      den_q <= den_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < den_q));

  // R9
  div_idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

endmodule

// File: rtl/clkcalc_ctl.sv
module clkcalc_ctl
  import clkcalc_pkg::*;
#(
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned OUT_W  = 32,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned DEN_W  = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        query_i,
  input  logic              pll_sel_i,
  input  logic [FRAC_W-1:0] tapa_frac_i,
  input  logic [FRAC_W-1:0] tapb_frac_i,
  input  logic [SRC_W-1:0]  src_sel_i,
  input  logic [AHB_W-1:0]  ahb_div_i,
  input  logic [IPG_W-1:0]  ipg_div_i,
  input  logic [FRAC_W-1:0] per_div_i,
  output logic              div_start_o,
  output logic [ACC_W-1:0]  div_num_o,
  output logic [DEN_W-1:0]  div_den_o,
  input  logic              div_done_i,
  input  logic [ACC_W-1:0]  div_quo_i,
  output logic              done_o,
  output logic [OUT_W-1:0]  freq_o
);
  localparam logic [ACC_W-1:0] PLL_HZ_HI  = ACC_W'(REF_HZ * PLL_MUL_HI);
  localparam logic [ACC_W-1:0] PLL_HZ_LO  = ACC_W'(REF_HZ * PLL_MUL_LO);
  localparam logic [ACC_W-1:0] SLOW_VAL   = ACC_W'(SLOW_HZ);
  localparam logic [ACC_W-1:0] REF_VAL    = ACC_W'(REF_HZ);
  localparam logic [ACC_W-1:0] REFDIV_VAL = ACC_W'(REF_HZ / REF_POST_DIV);

  typedef enum logic [3:0] {
    S_IDLE, S_TAP_GO, S_TAP_WT, S_AHB_GO, S_AHB_WT,
    S_IPG_GO, S_IPG_WT, S_PER_GO, S_PER_WT, S_OUT
  } state_e;

  state_e            state_q, state_n;
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic              acc_en, lat_en;
  logic [3:0]        query_q;
  logic              pll_sel_q;
  logic [FRAC_W-1:0] tapa_q, tapb_q, per_div_q;
  logic [SRC_W-1:0]  src_q;
  logic [AHB_W-1:0]  ahb_div_q;
  logic [IPG_W-1:0]  ipg_div_q;
  logic [ACC_W-1:0]  pll_hz;
  logic [FRAC_W-1:0] tap_frac;

  assign pll_hz   = pll_sel_q ? PLL_HZ_HI : PLL_HZ_LO;
  assign tap_frac = (src_q == SRC_W'(2)) ? tapa_q : tapb_q;

  always_comb begin
    state_n     = state_q;
    acc_n       = acc_q;
    acc_en      = 1'b0;
    lat_en      = 1'b0;
    div_start_o = 1'b0;
    div_num_o   = '0;
    div_den_o   = '0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          lat_en = 1'b1;
          acc_en = 1'b1;
          state_n = S_OUT;
          case (query_i)
            Q_IPG, Q_PER: begin acc_n = '0; state_n = S_TAP_GO; end
            Q_SLOW:       acc_n = SLOW_VAL;
            Q_REF:        acc_n = REF_VAL;
            Q_REF_DIV:    acc_n = REFDIV_VAL;
            default:      acc_n = '0;
          endcase
        end
      end
      S_TAP_GO: begin
        acc_en = 1'b1;
        if (src_q == '0) begin
          acc_n   = pll_hz;
          state_n = S_AHB_GO;
        end else if (tap_frac == '0) begin
          acc_n   = '0;
          state_n = S_AHB_GO;
        end else begin
          acc_en      = 1'b0;
          div_start_o = 1'b1;
          div_num_o   = pll_hz * ACC_W'(TAP_MUL);
          div_den_o   = DEN_W'(tap_frac);
          state_n     = S_TAP_WT;
        end
      end
      S_TAP_WT: begin
        if (div_done_i) begin
          acc_en  = 1'b1;
          acc_n   = (src_q == SRC_W'(3)) ? (div_quo_i >> 1) : div_quo_i;
          state_n = S_AHB_GO;
        end
      end
      S_AHB_GO: begin
        div_start_o = 1'b1;
        div_num_o   = acc_q;
        div_den_o   = DEN_W'(ahb_div_q) + DEN_W'(1);
        state_n     = S_AHB_WT;
      end
      S_AHB_WT: begin
        if (div_done_i) begin
          acc_en  = 1'b1;
          acc_n   = div_quo_i;
          state_n = S_IPG_GO;
        end
      end
      S_IPG_GO: begin
        div_start_o = 1'b1;
        div_num_o   = acc_q;
        div_den_o   = DEN_W'(ipg_div_q) + DEN_W'(1);
        state_n     = S_IPG_WT;
      end
      S_IPG_WT: begin
        if (div_done_i) begin
          acc_en  = 1'b1;
          acc_n   = div_quo_i;
          state_n = (query_q == Q_PER) ? S_PER_GO : S_OUT;
        end
      end
      S_PER_GO: begin
        div_start_o = 1'b1;
        div_num_o   = acc_q;
        div_den_o   = DEN_W'(per_div_q) + DEN_W'(1);
        state_n     = S_PER_WT;
      end
      S_PER_WT: begin
        if (div_done_i) begin
          acc_en  = 1'b1;
          acc_n   = div_quo_i;
          state_n = S_OUT;
        end
      end
      S_OUT:   state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      query_q   <= '0;
      pll_sel_q <= 1'b0;
      tapa_q    <= '0;
      tapb_q    <= '0;
      src_q     <= '0;
      ahb_div_q <= '0;
      ipg_div_q <= '0;
      per_div_q <= '0;
    end else if (lat_en) begin
      query_q   <= query_i;
      pll_sel_q <= pll_sel_i;
      tapa_q    <= tapa_frac_i;
      tapb_q    <= tapb_frac_i;
      src_q     <= src_sel_i;
      ahb_div_q <= ahb_div_i;
      ipg_div_q <= ipg_div_i;
      per_div_q <= per_div_i;
    end
  end

  assign done_o = (state_q == S_OUT);
  assign freq_o = acc_q[OUT_W-1:0];

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  query_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(query_q));

  // R8
  nonzero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start_o |-> (div_den_o != '0));

  // R7
  ref_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && query_q == Q_REF) |-> (freq_o == OUT_W'(REF_HZ)));

endmodule

// File: rtl/clkcalc_top.sv
module clkcalc_top
  import clkcalc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned OUT_W  = 32,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        query,
  input  logic [WORD_W-1:0] pll_word,
  input  logic [WORD_W-1:0] pfd_word,
  input  logic [WORD_W-1:0] mux_word,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [WORD_W-1:0] per_word,
  output logic              done,
  output logic [OUT_W-1:0]  freq
);
  localparam int unsigned DEN_W = FRAC_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             div_start, div_done;
  logic [ACC_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0] div_den;
  logic             unused_word_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign unused_word_bits = ^{pll_word, pfd_word, mux_word, bus_word, per_word};

  clkcalc_ctl #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .FRAC_W(FRAC_W),
    .DEN_W (DEN_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start),
    .query_i    (query),
    .pll_sel_i  (pll_word[PLL_SEL_BIT]),
    .tapa_frac_i(pfd_word[TAPA_LSB +: FRAC_W]),
    .tapb_frac_i(pfd_word[TAPB_LSB +: FRAC_W]),
    .src_sel_i  (mux_word[SRC_LSB +: SRC_W]),
    .ahb_div_i  (bus_word[AHB_LSB +: AHB_W]),
    .ipg_div_i  (bus_word[IPG_LSB +: IPG_W]),
    .per_div_i  (per_word[PER_LSB +: FRAC_W]),
    .div_start_o(div_start),
    .div_num_o  (div_num),
    .div_den_o  (div_den),
    .div_done_i (div_done),
    .div_quo_i  (div_quo),
    .done_o     (done),
    .freq_o     (freq)
  );

  clkcalc_div #(
    .NUM_W(ACC_W),
    .DEN_W(DEN_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  // R1
  idle_in_reset_chk: assert property (@(posedge clk)
    !rst_int_n |-> !done);

endmodule

// File: tb/clkcalc_top_test.sv
module clkcalc_top_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned OP_LIMIT   = 2000;
  localparam int unsigned WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  query = '0;
  logic [31:0] pll_word = '0, pfd_word = '0, mux_word = '0, bus_word = '0, per_word = '0;
  logic        done;
  logic [31:0] freq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int done_seen = 0;
  bit finished = 0;

  clkcalc_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .query(query),
    .pll_word(pll_word), .pfd_word(pfd_word), .mux_word(mux_word),
    .bus_word(bus_word), .per_word(per_word), .done(done), .freq(freq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (done) done_seen++;
    if (cycles > WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] model(logic [31:0] pw, logic [31:0] fw,
                                        logic [31:0] mw, logic [31:0] bw,
                                        logic [31:0] rw, logic [3:0] q);
    longint unsigned pll, ta, tb, src, ahb, ipg, per;
    pll = 64'd24_000_000 * (pw[0] ? 64'd22 : 64'd20);
    ta  = (fw[5:0] == 0) ? 0 : (pll * 18) / fw[5:0];
    tb  = (fw[21:16] == 0) ? 0 : (pll * 18) / fw[21:16];
    case (mw[19:18])
      2'd0: src = pll;
      2'd1: src = tb;
      2'd2: src = ta;
      default: src = tb / 2;
    endcase
    ahb = src / (64'd1 + bw[12:10]);
    ipg = ahb / (64'd1 + bw[9:8]);
    per = ipg / (64'd1 + rw[5:0]);
    case (q)
      4'd1: return ipg[31:0];
      4'd2: return per[31:0];
      4'd3: return 32'd32768;
      4'd4: return 32'd24_000_000;
      4'd5: return 32'd3_000_000;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0d (0x%08h) exp %0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run(string req, logic [31:0] pw, logic [31:0] fw, logic [31:0] mw,
                     logic [31:0] bw, logic [31:0] rw, logic [3:0] q,
                     output int lat, output logic [31:0] res);
    int n;
    int seen0;
    @(negedge clk);
    pll_word = pw; pfd_word = fw; mux_word = mw; bus_word = bw; per_word = rw;
    query = q; start = 1'b1;
    seen0 = done_seen;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < OP_LIMIT) begin
      @(negedge clk);
      n++;
    end
    lat = n;
    res = freq;
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s: act no done exp done within %0d", req, OP_LIMIT);
    end
    @(negedge clk);
    check({req, " R9 single pulse"}, 32'(done_seen - seen0), 32'd1);
  endtask

  task automatic run_chk(string req, logic [31:0] pw, logic [31:0] fw, logic [31:0] mw,
                         logic [31:0] bw, logic [31:0] rw, logic [3:0] q);
    int lat;
    logic [31:0] res;
    run(req, pw, fw, mw, bw, rw, q, lat, res);
    check(req, res, model(pw, fw, mw, bw, rw, q));
  endtask

  localparam logic [31:0] RP = 32'h0001_3001, RF = 32'h1018_101B,
                          RM = 32'h0002_2324, RB = 32'h0001_8D40, RR = 32'h00F0_0000;

  initial begin
    int lat;
    logic [31:0] res;
    int seen0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1
    check("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 freq after reset", freq, 32'd0);

    // R12 reset operating point
    run("R12 ipg", RP, RF, RM, RB, RR, 4'd1, lat, res);
    check("R12 ipg", res, 32'd66_000_000);
    run("R12 per", RP, RF, RM, RB, RR, 4'd2, lat, res);
    check("R12 per", res, 32'd66_000_000);

    // R2 pll multiplier, source 0, bus dividers 1
    run("R2 x22", 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 4'd1, lat, res);
    check("R2 x22", res, 32'd528_000_000);
    run("R2 x20", 32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0, 32'h0, 4'd1, lat, res);
    check("R2 x20", res, 32'd480_000_000);

    // R3 R4 tap fields and selector
    run("R4 sel1 tapB", RP, 32'h0018_001B, 32'h0004_0000, 32'h0, 32'h0, 4'd1, lat, res);
    check("R3 R4 sel1 tapB", res, 32'd396_000_000);
    run("R4 sel2 tapA", RP, 32'h0018_001B, 32'h0008_0000, 32'h0, 32'h0, 4'd1, lat, res);
    check("R3 R4 sel2 tapA", res, 32'd352_000_000);
    run("R4 sel3 half", RP, 32'h0018_001B, 32'h000C_0000, 32'h0, 32'h0, 4'd1, lat, res);
    check("R4 sel3 tapB half", res, 32'd198_000_000);
    run_chk("R3 truncation", 32'h0, 32'h0023_0011, 32'h000C_0000, 32'h0, 32'h0, 4'd1);

    // R5 bus dividers
    run_chk("R5 ahb div8 ipg div4", RP, RF, 32'h0, 32'h0000_1F00, 32'h0, 4'd1);
    run_chk("R5 ahb div3", 32'h0, RF, 32'h0008_0000, 32'h0000_0800, 32'h0, 4'd1);

    // R6 per divider
    run("R6 per div64", RP, RF, 32'h0, 32'h0, 32'h0000_003F, 4'd2, lat, res);
    check("R6 per div64", res, 32'd8_250_000);

    // R7 fixed clocks and latency
    run("R7 slow", RP, RF, RM, RB, RR, 4'd3, lat, res);
    check("R7 slow", res, 32'd32768);
    check("R7 slow latency", 32'(lat), 32'd1);
    run("R7 ref", RP, RF, RM, RB, RR, 4'd4, lat, res);
    check("R7 ref", res, 32'd24_000_000);
    run("R7 refdiv", RP, RF, RM, RB, RR, 4'd5, lat, res);
    check("R7 refdiv", res, 32'd3_000_000);
    check("R7 refdiv latency", 32'(lat), 32'd1);
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 5) continue;
      run("R7 other code", RP, RF, RM, RB, RR, 4'(c), lat, res);
      check("R7 other code zero", res, 32'd0);
    end

    // R8 zero fraction
    run("R8 tapA zero", RP, 32'h0018_0000, 32'h0008_0000, 32'h0, 32'h0, 4'd1, lat, res);
    check("R8 tapA zero", res, 32'd0);
    run("R8 tapB zero", RP, 32'h0000_001B, 32'h000C_0000, 32'h0, 32'h0, 4'd2, lat, res);
    check("R8 tapB zero", res, 32'd0);

    // R11 overflow wraps
    run("R11 wrap", RP, 32'h0000_0001, 32'h0008_0000, 32'h0, 32'h0, 4'd1, lat, res);
    check("R11 wrap", res, 32'd914_065_408);
    run_chk("R11 wrap after divide", RP, 32'h0001_0001, 32'h0004_0000, 32'h0000_0400, 32'h0, 4'd1);

    // R10 start while busy is ignored
    @(negedge clk);
    pll_word = RP; pfd_word = RF; mux_word = RM; bus_word = RB; per_word = RR;
    query = 4'd2; start = 1'b1;
    seen0 = done_seen;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    pll_word = 32'h0; pfd_word = 32'h0001_0001; mux_word = 32'h000C_0000;
    bus_word = 32'h0; per_word = 32'h0; query = 4'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 0;
      while (!done && n < OP_LIMIT) begin @(negedge clk); n++; end
    end
    check("R10 busy start ignored", freq, 32'd66_000_000);
    repeat (20) @(negedge clk);
    check("R10 one done only", 32'(done_seen - seen0), 32'd1);

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [31:0] pw, fw, mw, bw, rw;
      logic [3:0] q;
      pw = $urandom(); fw = $urandom(); mw = $urandom();
      bw = $urandom(); rw = $urandom();
      q = ($urandom() % 4 != 0) ? 4'(1 + $urandom() % 2) : 4'($urandom());
      run_chk("R2-chain random R5 R6", pw, fw, mw, bw, rw, q);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule